// File: doc/BRIEF.md
# Center-Aligned Dual-Slope PWM Timer

This block is a 16-bit up/down timer that produces center-aligned pulse-width modulation on a small group of compare channels. On each timer tick, the counter rises from zero to a programmable turning value. It then falls back to zero, and the cycle repeats. Because the counter sweeps both slopes, every pulse is centred on the turning point. This symmetry is what motor and power-stage control loops need.

The turning value and all compare values are written into holding registers. They are copied into the working registers only on the tick that leaves zero. As a result, each period runs on a single set of values and stays symmetric. One configuration bit selects the source of the turning value: either its own period register or the compare value of channel 0. When channel 0 supplies the turning value, its output becomes a square wave that flips at each peak. Each channel has a polarity bit and a sticky match flag, which is cleared by writing one.

Top module: `dspwm_timer`

## Requirements
- R1: While `tick` is high, the counter steps by one per clock. It rises from 0 to the effective peak and then falls back to 0, and it never exceeds the effective peak.
- R2: The counter stays at the peak for exactly one tick and at 0 for exactly one tick. With a peak of 3, successive ticks from 0 give 1,2,3,2,1,0,1,2.
- R3: When `cfg_top_from_a` is 0, the peak is the period register. When it is 1, the peak is the channel 0 compare value.
- R4: A peak value below 3 is treated as 3. The largest peak is 0xFFFF.
- R5: With a channel's `cfg_invert` bit at 0, a tick on which the counter equals the channel's compare value drives the output low if the counter is rising (including at the peak) and high if it is falling (including at 0). The output changes at the clock edge of that tick.
- R6: With `cfg_invert` at 1, the channel output is the exact complement of the level R5 gives. The polarity bit takes effect one clock after `cfg_we`.
- R7: A channel's match flag is set on each tick on which its compare condition holds. It then stays set until a `flag_clr` bit for that channel arrives on a cycle without a new match. When both happen in the same cycle, the set takes priority.
- R8: Writes to the period register, the compare registers and the peak-source bit go to holding registers. These are copied into the working registers on the tick that leaves 0, so a value written mid-period does not alter the running period.
- R9: When channel 0 supplies the peak, its match condition is reaching the peak, and its output toggles on each such tick.
- R10: With `tick` low, the counter, the outputs and the flags do not change, apart from flag clears.
- R11: A synchronous `rst` sets the following: counter 0 in its falling phase, period register and working peak 0xFFFF, compare values 0, period-register mode, non-inverting polarity, outputs low and flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer tick enable |
| top_we | input | 1 | Write strobe for the period holding register |
| top_wdata | input | 16 | Period value to write |
| cmp_we | input | 3 | Per-channel write strobe for compare holding registers |
| cmp_wdata | input | 16 | Compare value to write |
| cfg_we | input | 1 | Write strobe for configuration |
| cfg_top_from_a | input | 1 | 1: channel 0 compare supplies the peak (held until reload) |
| cfg_invert | input | 3 | Per-channel inverting polarity |
| flag_clr | input | 3 | Per-channel write-one-to-clear of match flags |
| count | output | 16 | Current counter value |
| pwm_out | output | 3 | PWM outputs |
| match_flag | output | 3 | Sticky match flags |

## Verification
Directed runs cover four cases: the exact sequence at the smallest peak, an undersized peak write, the peak supplied by channel 0, and a period rewritten partway through a period, which must take effect only after the next visit to zero. Random runs draw peaks near the floor together with compare values that include 0, the peak and values above it. They also mix in polarity, mode switches, sparse ticks, and writes and flag clears that arrive mid-period or in the same cycle as a match. This separates clear-while-rising from set-while-falling, toggle mode from normal mode, and set-over-clear priority. Each cycle, the bench checks the count, outputs and flags against a model computed from the requirements.

// File: rtl/dspwm_timer.sv
module dspwm_timer #(
  parameter int W       = 16,
  parameter int NCH     = 3,
  parameter int MIN_TOP = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           top_we,
  input  logic [W-1:0]   top_wdata,
  input  logic [NCH-1:0] cmp_we,
  input  logic [W-1:0]   cmp_wdata,
  input  logic           cfg_we,
  input  logic           cfg_top_from_a,
  input  logic [NCH-1:0] cfg_invert,
  input  logic [NCH-1:0] flag_clr,
  output logic [W-1:0]   count,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] match_flag
);

  localparam logic [W-1:0] FLOOR = W'(MIN_TOP);

  function automatic logic [W-1:0] floor_top(input logic [W-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  logic [W-1:0]          cnt_q, top_buf, top_act, top_eff;
  logic [NCH-1:0][W-1:0] cmp_buf, cmp_act;
  logic                  mode_buf, mode_act, up_q;
  logic [NCH-1:0]        inv_q, lvl_q, flag_q;
  logic                  at_top, at_bot, reload;

  assign top_eff = mode_act ? floor_top(cmp_act[0]) : top_act;
  assign at_top  = up_q && (cnt_q == top_eff);
  assign at_bot  = !up_q && (cnt_q == '0);
  assign reload  = tick && at_bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_buf  <= '1;
      cmp_buf  <= '0;
      mode_buf <= 1'b0;
      inv_q    <= '0;
    end else begin
      if (top_we) top_buf <= top_wdata;
      for (int i = 0; i < NCH; i++)
        if (cmp_we[i]) cmp_buf[i] <= cmp_wdata;
      if (cfg_we) begin
        mode_buf <= cfg_top_from_a;
        inv_q    <= cfg_invert;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_act  <= '1;
      cmp_act  <= '0;
      mode_act <= 1'b0;
    end else if (reload) begin
      top_act  <= floor_top(top_buf);
      cmp_act  <= cmp_buf;
      mode_act <= mode_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (tick) begin
      if (at_top) begin
        cnt_q <= cnt_q - 1'b1;
        up_q  <= 1'b0;
      end else if (at_bot) begin
        cnt_q <= {{(W-1){1'b0}}, 1'b1};
        up_q  <= 1'b1;
      end else if (up_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit IS_A = (i == 0);
    logic tgl, hit, lvl, flg;

    assign tgl = IS_A && mode_act;
    assign hit = tgl ? at_top : (cnt_q == cmp_act[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl <= 1'b0;
        flg <= 1'b0;
      end else begin
        if (tick && hit) lvl <= tgl ? ~lvl : ~up_q;
        if (tick && hit)      flg <= 1'b1;
        else if (flag_clr[i]) flg <= 1'b0;
      end
    end

    assign lvl_q[i]  = lvl;
    assign flag_q[i] = flg;
  end

  assign count      = cnt_q;
  assign pwm_out    = lvl_q ^ inv_q;
  assign match_flag = flag_q;

endmodule

// File: rtl/dspwm_timer_chk.sv
module dspwm_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           up,
  input logic [W-1:0]   count,
  input logic [W-1:0]   top_eff,
  input logic [NCH-1:0] flag_clr,
  input logic [NCH-1:0] match_flag
);

  assert_within_top_R1: assert property (@(posedge clk) disable iff (rst)
    count <= top_eff);

  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    top_eff >= W'(3));

  assert_top_turn_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && up && count == top_eff) |=> (count == $past(count) - 1'b1) && !up);

  assert_bottom_turn_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !up && count == '0) |=> (count == W'(1)) && up);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count) && $stable(up));

  for (genvar i = 0; i < NCH; i++) begin : g_f
    assert_flag_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(match_flag[i]) |-> $past(tick));
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[i] && !tick) |=> !match_flag[i]);
  end

endmodule

bind dspwm_timer dspwm_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .up(up_q), .count(cnt_q),
  .top_eff(top_eff), .flag_clr(flag_clr), .match_flag(flag_q)
);

// File: tb/dspwm_timer_test.sv
module dspwm_timer_test;
  localparam int W = 16, NCH = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, top_we = 1'b0, cfg_we = 1'b0, cfg_top_from_a = 1'b0;
  logic [W-1:0] top_wdata = '0, cmp_wdata = '0;
  logic [NCH-1:0] cmp_we = '0, cfg_invert = '0, flag_clr = '0;
  logic [W-1:0] count;
  logic [NCH-1:0] pwm_out, match_flag;

  dspwm_timer #(.W(W), .NCH(NCH)) uut (
    .clk(clk), .rst(rst), .tick(tick), .top_we(top_we), .top_wdata(top_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cfg_we(cfg_we),
    .cfg_top_from_a(cfg_top_from_a), .cfg_invert(cfg_invert), .flag_clr(flag_clr),
    .count(count), .pwm_out(pwm_out), .match_flag(match_flag));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [W-1:0] m_cnt, m_top, m_topb;
  logic [W-1:0] m_cmp [NCH];
  logic [W-1:0] m_cmpb [NCH];
  logic m_up, m_mode, m_modeb;
  logic [NCH-1:0] m_inv, m_lvl, m_flag;

  function automatic logic [W-1:0] floor3(input logic [W-1:0] v);
    return (v < 16'd3) ? 16'd3 : v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [W-1:0] te;
    logic atop, abot, hit, tg;
    if (rst) begin
      m_cnt = '0; m_up = 1'b0; m_top = '1; m_topb = '1; m_mode = 1'b0; m_modeb = 1'b0;
      m_inv = '0; m_lvl = '0; m_flag = '0;
      for (int i = 0; i < NCH; i++) begin m_cmp[i] = '0; m_cmpb[i] = '0; end
      return;
    end
    te = m_mode ? floor3(m_cmp[0]) : m_top;
    atop = m_up && (m_cnt == te);
    abot = !m_up && (m_cnt == '0);
    for (int i = 0; i < NCH; i++) begin
      tg  = (i == 0) && m_mode;
      hit = tg ? atop : (m_cnt == m_cmp[i]);
      if (tick && hit) begin
        m_flag[i] = 1'b1;
        m_lvl[i]  = tg ? ~m_lvl[i] : ~m_up;
      end else if (flag_clr[i]) m_flag[i] = 1'b0;
    end
    if (tick) begin
      if (atop) begin m_cnt = m_cnt - 1'b1; m_up = 1'b0; end
      else if (abot) begin
        m_cnt = 16'd1; m_up = 1'b1;
        m_top = floor3(m_topb); m_mode = m_modeb;
        for (int i = 0; i < NCH; i++) m_cmp[i] = m_cmpb[i];
      end else if (m_up) m_cnt = m_cnt + 1'b1;
      else m_cnt = m_cnt - 1'b1;
    end
    if (top_we) m_topb = top_wdata;
    for (int i = 0; i < NCH; i++) if (cmp_we[i]) m_cmpb[i] = cmp_wdata;
    if (cfg_we) begin m_modeb = cfg_top_from_a; m_inv = cfg_invert; end
  endtask

  task automatic step(input bit tk);
    tick = tk;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tk ? "R1" : "R10", "count", count, m_cnt);
    for (int i = 0; i < NCH; i++) begin
      chk((i == 0 && m_mode) ? "R9" : (m_inv[i] ? "R6" : "R5"), $sformatf("pwm%0d", i),
          pwm_out[i], m_lvl[i] ^ m_inv[i]);
      chk("R7", $sformatf("flag%0d", i), match_flag[i], m_flag[i]);
    end
    tick = 1'b0; top_we = 1'b0; cmp_we = '0; cfg_we = 1'b0; flag_clr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(1'b0); rst = 1'b0;
  endtask

  task automatic wr_top(input logic [W-1:0] v);
    top_we = 1'b1; top_wdata = v; step(1'b0);
  endtask

  task automatic wr_cmp(input int ch, input logic [W-1:0] v);
    cmp_we = '0; cmp_we[ch] = 1'b1; cmp_wdata = v; step(1'b0);
  endtask

  task automatic wr_cfg(input logic md, input logic [NCH-1:0] inv);
    cfg_we = 1'b1; cfg_top_from_a = md; cfg_invert = inv; step(1'b0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
    int pk;
    void'($urandom(32'd20240611));
    do_reset(); step(1'b0);
    chk("R11", "reset count", count, 0);
    chk("R11", "reset pwm", pwm_out, 0);
    chk("R11", "reset flags", match_flag, 0);

    // R2: exact sequence at the smallest peak
    do_reset(); wr_top(16'd3);
    for (int k = 0; k < 8; k++) begin
      step(1'b1);
      chk("R2", "sequence", count, seq[k]);
    end

    // R4: peak below the floor behaves as 3
    do_reset(); wr_top(16'd1); pk = 0;
    for (int k = 0; k < 12; k++) begin step(1'b1); if (count > pk) pk = count; end
    chk("R4", "peak floor", pk, 3);

    // R3: channel 0 compare supplies the peak
    do_reset(); wr_top(16'd9); wr_cmp(0, 16'd5); wr_cfg(1'b1, '0); pk = 0;
    for (int k = 0; k < 20; k++) begin step(1'b1); if (count > pk) pk = count; end
    chk("R3", "peak from ch0", pk, 5);

    // R8: mid-period write held until the counter leaves 0
    do_reset(); wr_top(16'd6);
    step(1'b1); step(1'b1);
    wr_top(16'd4); pk = 0;
    while (count != 0) begin step(1'b1); if (count > pk) pk = count; end
    chk("R8", "old period kept", pk, 6);
    pk = 0;
    for (int k = 0; k < 8; k++) begin step(1'b1); if (count > pk) pk = count; end
    chk("R8", "new period used", pk, 4);

    // R10: counter frozen without ticks
    pk = count;
    for (int k = 0; k < 5; k++) step(1'b0);
    chk("R10", "frozen count", count, pk);

    // constrained random runs
    for (int c = 0; c < 24; c++) begin
      do_reset();
      wr_top(16'($urandom_range(0, 20)));
      for (int i = 0; i < NCH; i++) wr_cmp(i, 16'($urandom_range(0, 22)));
      wr_cfg(1'($urandom_range(0, 2) == 0), NCH'($urandom));
      for (int k = 0; k < 300; k++) begin
        case ($urandom_range(0, 19))
          0: begin top_we = 1'b1; top_wdata = 16'($urandom_range(0, 20)); end
          1: begin cmp_we = NCH'(1 << $urandom_range(0, NCH - 1));
                   cmp_wdata = 16'($urandom_range(0, 22)); end
          2: begin cfg_we = 1'b1; cfg_top_from_a = 1'($urandom_range(0, 1));
                   cfg_invert = NCH'($urandom); end
          default: ;
        endcase
        if ($urandom_range(0, 5) == 0) flag_clr = NCH'($urandom);
        step($urandom_range(0, 3) != 0);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule